// File: doc/BRIEF.md
# Write-Through Cache Controller

This block manages a small direct-mapped cache that sits between a processor core and an external bus. Each line holds four 32-bit words (16 bytes) and has its own valid bit. For every core read or write, and for every external invalidate, the controller decides four things: whether the cache supplies the data, whether a miss fills a line, whether a write goes out on the bus, and whether an invalidate clears a line.

Two mode pins set the policy. `cfg_cache_dis` stops line fills. `cfg_wt_dis` stops write-through and also stops invalidation. When both are set, the cache works as a fast static RAM. The combination with caching on and write-through off is illegal. The block raises `cfg_error` for it and then behaves exactly as in static-RAM mode.

Requests enter through a valid/ready port. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while a bus transfer is outstanding. The core must hold the request stable until it is accepted. The response is a single-cycle `rsp_valid` pulse with no back-pressure. Bus requests use valid/ready as well. The block holds `bus_req_valid` and all request fields stable until `bus_req_ready` is seen. Read data returns on `bus_rvalid` beats. Beats cannot be stalled.

Top module: `wt_cache_ctrl`

## Requirements
- R1: A read hit returns the cached word with `rsp_hit`=1 one cycle after acceptance, and issues no bus request.
- R2: A read miss with caching enabled (`cfg_cache_dis`=0, `cfg_wt_dis`=0) and `req_cacheable`=1 issues one bus read with `bus_req_line`=1 and address bits [3:0] zero. Four beats follow, carrying words 0..3 in ascending order. The line becomes valid only if `bus_cache_en` is 1 on the last beat.
- R3: Any other read miss issues a single-beat read with `bus_req_line`=0 and fills nothing. This applies when the page is uncacheable or caching is disabled. The response word is always the bus data for the requested address, and `rsp_hit`=0.
- R4: With `cfg_cache_dis`=1, lines that are already valid still serve read hits without bus traffic.
- R5: A one-cycle `flush` clears every valid bit by the next cycle. Every read after it goes to the bus.
- R6: With `cfg_wt_dis`=0, every write issues a single bus write (`bus_req_write`=1), hit or miss. A write hit also updates the cached word.
- R7: With `cfg_wt_dis`=1, a write hit updates only the cached word. It issues no bus write and responds one cycle after acceptance.
- R8: A write miss always issues a bus write and never allocates a line.
- R9: With `cfg_wt_dis`=0, `inv_valid` with an address that matches a valid line clears that line. With `cfg_wt_dis`=1, invalidates have no effect.
- R10: `cfg_error` is 1 exactly when `cfg_cache_dis`=0 and `cfg_wt_dis`=1. In that mode the block does no fills, no write-through and no invalidation.
- R11: `req_ready` is low while `busy` is high. A bus request that is waiting for `bus_req_ready` keeps its address and direction stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cache_dis | input | 1 | 1 = no line fills |
| cfg_wt_dis | input | 1 | 1 = no write-through, no invalidation |
| cfg_error | output | 1 | Illegal mode combination |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_cacheable | input | 1 | Page allows caching |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | DATA_W | Read data |
| rsp_hit | output | 1 | Response came from the cache |
| busy | output | 1 | Bus transfer outstanding |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus accepts request |
| bus_req_write | output | 1 | 1 = single write |
| bus_req_line | output | 1 | 1 = four-beat line read |
| bus_req_addr | output | ADDR_W | Bus byte address |
| bus_req_wdata | output | DATA_W | Bus write data |
| bus_rvalid | input | 1 | Read beat valid |
| bus_rdata | input | DATA_W | Read beat data |
| bus_cache_en | input | 1 | External cacheability for the current read |
| flush | input | 1 | Invalidate all lines |
| inv_valid | input | 1 | External invalidate strobe |
| inv_addr | input | ADDR_W | Invalidate address |

## Verification
Most wrong internal states show up at the ports one request later. A valid bit that was wrongly set or cleared flips the next read of that address between a silent hit and a bus read. A stale data word appears on `rsp_rdata` at the first hit. A fill that was committed when it should not have been, or an invalidate that was wrongly honoured, is therefore visible on the following read of the same line. The bench exploits this by following every policy-sensitive action with a read-back in all four modes.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RD_REQ  = 2'd1,
    ST_RD_DATA = 2'd2,
    ST_WR_REQ  = 2'd3
  } cc_state_e;

  typedef struct packed {
    logic fill_ok;
    logic wt_on;
    logic inv_on;
    logic cfg_err;
  } cc_policy_t;

endpackage

// File: rtl/cc_mode_decode.sv
module cc_mode_decode
  import cc_pkg::*;
(
  input  logic       cache_dis,
  input  logic       wt_dis,
  output cc_policy_t pol
);
  // Illegal combination (caching on, write-through off) is folded into the
  // static-RAM behaviour: no fills, no write-through, no invalidation.
  always_comb begin
    pol.cfg_err = !cache_dis && wt_dis;
    pol.fill_ok = !cache_dis && !wt_dis;
    pol.wt_on   = !wt_dis;
    pol.inv_on  = !wt_dis;
  end
endmodule

// File: rtl/cc_tag_store.sv
module cc_tag_store #(
  parameter int SETS  = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             flush,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  output logic [SETS-1:0]  valid_vec
);
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic inv_here;
    logic clr_here;
    logic set_here;
    assign inv_here = inv_en && (inv_idx == IDX_W'(g)) && (tag_q[g] == inv_tag);
    assign clr_here = clr_en && (clr_idx == IDX_W'(g));
    assign set_here = set_en && (set_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_vec[g] <= 1'b0;
        tag_q[g]     <= '0;
      end else if (flush) begin
        valid_vec[g] <= 1'b0;
      end else if (inv_here || clr_here) begin
        valid_vec[g] <= 1'b0;
      end else if (set_here) begin
        valid_vec[g] <= 1'b1;
        tag_q[g]     <= set_tag;
      end
    end
  end

  assign lk_hit = valid_vec[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/cc_data_store.sv
module cc_data_store #(
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  localparam int DEPTH     = SETS * LINE_WORDS,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import cc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cache_dis,
  input  logic              cfg_wt_dis,
  output logic              cfg_error,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_cacheable,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic              busy,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic              bus_req_line,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_cache_en,
  input  logic              flush,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1;
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int DAW    = IDX_W + WSEL_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  cc_policy_t pol;
  cc_state_e  state_q;

  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic              q_fill;
  logic              kill_q;
  logic [WSEL_W-1:0] beat_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_hit_q;

  logic [SETS-1:0]   valid_vec;
  logic              lookup_hit;
  logic [DATA_W-1:0] ds_rdata;
  logic              ds_we;
  logic [DAW-1:0]    ds_waddr;
  logic [DATA_W-1:0] ds_wdata;

  logic [IDX_W-1:0]  req_idx, q_idx, inv_idx;
  logic [TAG_W-1:0]  req_tag, q_tag, inv_tag;
  logic [WSEL_W-1:0] req_wsel, q_wsel;

  logic accept, inv_eff, kill_now, last_beat, start_fill, commit_fill, wr_hit;

  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_wsel = req_addr[BYTE_W +: WSEL_W];
  assign q_idx    = q_addr[OFF_W +: IDX_W];
  assign q_tag    = q_addr[ADDR_W-1 -: TAG_W];
  assign q_wsel   = q_addr[BYTE_W +: WSEL_W];
  assign inv_idx  = inv_addr[OFF_W +: IDX_W];
  assign inv_tag  = inv_addr[ADDR_W-1 -: TAG_W];

  cc_mode_decode u_mode (
    .cache_dis (cfg_cache_dis),
    .wt_dis    (cfg_wt_dis),
    .pol       (pol)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign inv_eff   = inv_valid && pol.inv_on;
  assign wr_hit    = accept && req_write && lookup_hit;

  // A flush or a matching invalidate during a fill cancels the commit.
  assign kill_now  = flush || (inv_eff && (inv_idx == q_idx) && (inv_tag == q_tag));
  assign last_beat = !q_fill || (beat_q == LAST_BEAT);
  assign start_fill  = accept && !req_write && !lookup_hit &&
                       pol.fill_ok && req_cacheable;
  assign commit_fill = (state_q == ST_RD_DATA) && bus_rvalid && last_beat &&
                       q_fill && bus_cache_en && !kill_q && !kill_now;

  cc_tag_store #(
    .SETS  (SETS),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (req_idx),
    .lk_tag    (req_tag),
    .lk_hit    (lookup_hit),
    .flush     (flush),
    .inv_en    (inv_eff),
    .inv_idx   (inv_idx),
    .inv_tag   (inv_tag),
    .clr_en    (start_fill),
    .clr_idx   (req_idx),
    .set_en    (commit_fill),
    .set_idx   (q_idx),
    .set_tag   (q_tag),
    .valid_vec (valid_vec)
  );

  always_comb begin
    ds_we    = 1'b0;
    ds_waddr = {req_idx, req_wsel};
    ds_wdata = req_wdata;
    if (wr_hit) begin
      ds_we = 1'b1;
    end else if ((state_q == ST_RD_DATA) && bus_rvalid && q_fill) begin
      ds_we    = 1'b1;
      ds_waddr = {q_idx, beat_q};
      ds_wdata = bus_rdata;
    end
  end

  cc_data_store #(
    .SETS       (SETS),
    .LINE_WORDS (LINE_WORDS),
    .DATA_W     (DATA_W)
  ) u_data (
    .clk   (clk),
    .we    (ds_we),
    .waddr (ds_waddr),
    .wdata (ds_wdata),
    .raddr ({req_idx, req_wsel}),
    .rdata (ds_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      q_addr      <= '0;
      q_wdata     <= '0;
      q_fill      <= 1'b0;
      kill_q      <= 1'b0;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            kill_q  <= 1'b0;
            beat_q  <= '0;
            if (!req_write) begin
              if (lookup_hit) begin
                rsp_valid_q <= 1'b1;
                rsp_data_q  <= ds_rdata;
                rsp_hit_q   <= 1'b1;
              end else begin
                q_fill  <= pol.fill_ok && req_cacheable;
                state_q <= ST_RD_REQ;
              end
            end else if (pol.wt_on || !lookup_hit) begin
              state_q <= ST_WR_REQ;
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
            end
          end
        end
        ST_RD_REQ: begin
          kill_q <= kill_q || kill_now;
          if (bus_req_ready) state_q <= ST_RD_DATA;
        end
        ST_RD_DATA: begin
          kill_q <= kill_q || kill_now;
          if (bus_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (!q_fill || (beat_q == q_wsel)) rsp_data_q <= bus_rdata;
            if (last_beat) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b0;
              state_q     <= ST_IDLE;
            end
          end
        end
        ST_WR_REQ: begin
          if (bus_req_ready) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_valid = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
    bus_req_write = (state_q == ST_WR_REQ);
    bus_req_line  = (state_q == ST_RD_REQ) && q_fill;
    bus_req_wdata = q_wdata;
    if (bus_req_line) bus_req_addr = {q_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    else              bus_req_addr = q_addr;
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign rsp_hit   = rsp_hit_q;
  assign cfg_error = pol.cfg_err;
endmodule

// File: rtl/cc_checker.sv
module cc_checker #(
  parameter int ADDR_W = 12,
  parameter int SETS   = 4,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              cfg_wt_dis,
  input logic              flush,
  input logic              inv_valid,
  input logic              busy,
  input logic              lookup_hit,
  input logic              bus_req_valid,
  input logic              bus_req_ready,
  input logic              bus_req_line,
  input logic              bus_req_write,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              rsp_valid,
  input logic              cfg_error,
  input logic [SETS-1:0]   valid_vec
);
  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=>
      bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_write));

  // R11
  accept_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || busy);

  // R1
  read_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && lookup_hit |=> rsp_valid && !busy);

  // R7
  wt_off_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && lookup_hit && cfg_wt_dis |=>
      rsp_valid && !bus_req_valid);

  // R2
  line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && bus_req_line |->
      (bus_req_addr[OFF_W-1:0] == '0) && !bus_req_write);

  // R10
  err_nofill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error && bus_req_valid |-> !bus_req_line);

  // R5
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0);

  // R9
  inv_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid && cfg_wt_dis && !flush && !busy && !req_valid |=> $stable(valid_vec));
endmodule

bind wt_cache_ctrl cc_checker #(
  .ADDR_W (ADDR_W),
  .SETS   (SETS),
  .OFF_W  (OFF_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .cfg_wt_dis    (cfg_wt_dis),
  .flush         (flush),
  .inv_valid     (inv_valid),
  .busy          (busy),
  .lookup_hit    (lookup_hit),
  .bus_req_valid (bus_req_valid),
  .bus_req_ready (bus_req_ready),
  .bus_req_line  (bus_req_line),
  .bus_req_write (bus_req_write),
  .bus_req_addr  (bus_req_addr),
  .rsp_valid     (rsp_valid),
  .cfg_error     (cfg_error),
  .valid_vec     (valid_vec)
);

// File: tb/wt_cache_ctrl_tb.sv
module wt_cache_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cache_dis = 1'b0, cfg_wt_dis = 1'b0;
  logic cfg_error;
  logic req_valid = 1'b0, req_write = 1'b0, req_cacheable = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit, busy;
  logic [DW-1:0] rsp_rdata;
  logic bus_req_valid, bus_req_write, bus_req_line;
  logic bus_req_ready = 1'b0;
  logic [AW-1:0] bus_req_addr;
  logic [DW-1:0] bus_req_wdata;
  logic bus_rvalid = 1'b0, bus_cache_en = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic flush = 1'b0, inv_valid = 1'b0;
  logic [AW-1:0] inv_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_cache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cache_dis(cfg_cache_dis), .cfg_wt_dis(cfg_wt_dis), .cfg_error(cfg_error),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_cacheable(req_cacheable),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_hit(rsp_hit), .busy(busy),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_write(bus_req_write), .bus_req_line(bus_req_line),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_cache_en(bus_cache_en),
    .flush(flush), .inv_valid(inv_valid), .inv_addr(inv_addr)
  );

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0;
  logic last_line = 1'b0;
  logic smp_busy = 1'b0, smp_ready = 1'b0;
  logic tb_done = 1'b0;
  logic [DW-1:0] mem [0:1023];

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int set, input int w);
    return {6'(tag), 2'(set), 2'(w), 2'b00};
  endfunction

  // Bus responder
  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = (i * 32'h9E3779B1) + 32'd7;
    forever begin
      @(negedge clk);
      bus_req_ready = 1'b0;
      bus_rvalid = 1'b0;
      if (bus_req_valid) begin
        bus_req_ready = 1'b1;
        if (bus_req_write) begin
          mem[bus_req_addr >> 2] = bus_req_wdata;
          n_wr++;
        end else begin
          logic [AW-1:0] a;
          logic ln;
          a = bus_req_addr;
          ln = bus_req_line;
          last_line = ln;
          n_rd++;
          @(negedge clk);
          bus_req_ready = 1'b0;
          for (int b = 0; b < (ln ? 4 : 1); b++) begin
            bus_rvalid = 1'b1;
            bus_rdata = mem[(a >> 2) + b];
            @(negedge clk);
          end
          bus_rvalid = 1'b0;
        end
      end
    end
  end

  task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic cach, output logic [DW-1:0] rd, output logic hit);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_cacheable = cach;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    smp_busy = busy; smp_ready = req_ready;
    n = 0;
    while (!rsp_valid && n < 64) begin @(negedge clk); n++; end
    rd = rsp_rdata;
    hit = rsp_hit;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic do_inv(input logic [AW-1:0] a);
    @(negedge clk); inv_valid = 1'b1; inv_addr = a;
    @(negedge clk); inv_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!tb_done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    logic hit;
    logic [AW-1:0] a, b;
    int r0, w0;
    repeat (3) @(negedge clk);
    chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;

    // Sweep 1: every mode x set x page flag x external enable
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int p = 0; p < 2; p++) begin
          for (int c = 0; c < 2; c++) begin
            logic cd, wdis, fill_ok;
            cd = m[1]; wdis = m[0];
            fill_ok = !cd && !wdis;
            do_flush();
            cfg_cache_dis = cd; cfg_wt_dis = wdis; bus_cache_en = c[0];
            a = mk(s + 4 * p + 8 * c + 1, s, (s + p) % 4);
            @(negedge clk);
            chk("R10 cfg_error", {31'd0, cfg_error}, {31'd0, !cd && wdis});
            r0 = n_rd;
            cpu_op(1'b0, a, '0, p[0], rd, hit);
            chk("R11 busy during miss", {30'd0, smp_busy, smp_ready}, 32'd2);
            chk("R3 miss data", rd, mem[a >> 2]);
            chk("R3 miss not hit", {31'd0, hit}, 32'd0);
            chk("R2 one bus read", n_rd - r0, 1);
            chk("R2 line flag", {31'd0, last_line}, {31'd0, fill_ok && p[0]});
            r0 = n_rd;
            cpu_op(1'b0, a, '0, p[0], rd, hit);
            chk("R2 refetch hit", {31'd0, hit}, {31'd0, fill_ok && p[0] && c[0]});
            chk("R1 refetch bus reads", n_rd - r0, (fill_ok && p[0] && c[0]) ? 0 : 1);
            chk("R1 refetch data", rd, mem[a >> 2]);
          end
        end
      end
    end

    // Sweep 2: preloaded line, then each mode
    for (int m = 0; m < 4; m++) begin
      logic wdis;
      logic [DW-1:0] nv, bv;
      wdis = m[0];
      a = mk(3, m, 1);
      b = mk(9, (m + 1) % 4, 2);
      nv = 32'hC0DE0000 + m;
      bv = 32'hBEEF0000 + m;
      do_flush();
      cfg_cache_dis = 1'b0; cfg_wt_dis = 1'b0; bus_cache_en = 1'b1;
      cpu_op(1'b0, a, '0, 1'b1, rd, hit);
      cfg_cache_dis = m[1]; cfg_wt_dis = wdis;
      r0 = n_rd;
      cpu_op(1'b0, a, '0, 1'b1, rd, hit);
      chk("R4 preloaded hit", {31'd0, hit}, 32'd1);
      chk("R4 no bus read", n_rd - r0, 0);
      w0 = n_wr;
      cpu_op(1'b1, a, nv, 1'b1, rd, hit);
      chk(wdis ? "R7 hit no bus write" : "R6 hit writes through", n_wr - w0, wdis ? 0 : 1);
      r0 = n_rd;
      cpu_op(1'b0, a, '0, 1'b1, rd, hit);
      chk("R6 R7 cached word updated", rd, nv);
      chk("R6 R7 read after write hits", n_rd - r0, 0);
      w0 = n_wr;
      cpu_op(1'b1, b, bv, 1'b1, rd, hit);
      chk("R8 write miss to bus", n_wr - w0, 1);
      r0 = n_rd;
      cpu_op(1'b0, b, '0, 1'b1, rd, hit);
      chk("R8 no allocate", {31'd0, hit}, 32'd0);
      chk("R8 miss data from bus", rd, bv);
      do_inv(a);
      r0 = n_rd;
      cpu_op(1'b0, a, '0, 1'b1, rd, hit);
      chk(wdis ? "R9 invalidate ignored" : "R9 invalidate clears", {31'd0, hit}, {31'd0, wdis});
      chk("R9 data after invalidate", rd, nv);
      do_flush();
      r0 = n_rd;
      cpu_op(1'b0, a, '0, 1'b1, rd, hit);
      chk("R5 read after flush goes to bus", n_rd - r0, 1);
      chk("R5 read after flush misses", {31'd0, hit}, 32'd0);
    end

    tb_done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule